// File: doc/BRIEF.md
# Saturating Rounding Fractional Multiplier

This unit multiplies two signed fixed-point fractions of SEW bits each, one element per clock. It forms the full double-width product, shifts it right arithmetically by SEW-1 bit positions so the result is a fraction of the same format again, and adds a rounding increment chosen by a 2-bit mode input. A result that does not fit in SEW signed bits is clamped to the nearest representable extreme, and a sticky flag records that this happened.

The first operand is taken either from a per-element input or from a scalar input that is reused for every element. The choice is made by a select bit that is sampled with each element. The second operand always comes from the per-element input. Elements enter with a valid strobe and leave two cycles later with a matching output strobe. Back-to-back issue is allowed on every cycle. The rounding mode travels down the pipeline with its element. A clear input resets the sticky flag.

Top module: `sat_frac_mul`

## Requirements
- R1: For valid elements, `result` equals the signed product of the two operands shifted arithmetically right by SEW-1 bits, plus the rounding increment, and is kept in SEW bits. With d = SEW-1 and p the product, the increment is set by `roundMode`.
- R2: With `roundMode` = 0 (nearest, ties up), the increment is p[d-1].
- R3: With `roundMode` = 1 (nearest, ties to even), the increment is p[d-1] & (p[d] | (p[d-2:0] != 0)).
- R4: With `roundMode` = 2 (truncate), the increment is 0.
- R5: With `roundMode` = 3 (round to odd), the increment is !p[d] & (p[d-1:0] != 0).
- R6: When the rounded value is above the largest positive SEW-bit value, `result` is that largest value. When it is below the most negative value, `result` is the most negative value. Either event sets `satFlag` in the same cycle that the clamped result appears. Only the case where both operands are the most negative value can overflow.
- R7: `satFlag` stays set until `satClear` is asserted.
- R8: `satClear` clears `satFlag` at the next edge. If an element that saturates completes at that same edge, the flag is set instead.
- R9: When `scalarSel` = 1, the first operand is `scalarA` and `vecA` has no effect. When `scalarSel` = 0, the first operand is `vecA`.
- R10: `outValid` is high exactly two cycles after `inValid`, and elements may be issued on consecutive cycles.
- R11: A synchronous active-low reset clears `outValid` and `satFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Element present on the inputs |
| scalarSel | input | 1 | 1: the first operand comes from scalarA |
| vecA | input | SEW | Per-element first operand |
| scalarA | input | SEW | Broadcast first operand |
| vecB | input | SEW | Per-element second operand |
| roundMode | input | 2 | 0 ties up, 1 ties even, 2 truncate, 3 round to odd |
| satClear | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Result is valid |
| result | output | SEW | Rounded, clamped fractional product |
| satFlag | output | 1 | Sticky saturation indicator |

## Verification
Operands are chosen so that the discarded fraction is exactly one half, with both even and odd kept parts, and with both positive and negative products. This separates the four rounding modes from one another on the same data. A general mix of operand pairs is checked in every mode against an independent model. A stream of consecutive elements with changing modes and select values shows that each mode stays with its own element. The most-negative-squared case, combined with clears that come alone and clears that coincide with a saturating element, separates sticky behaviour from the clear priority rule.

// File: rtl/sat_frac_mul_pkg.sv
package sat_frac_mul_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_TRUNC     = 2'd2,
    RND_ODD       = 2'd3
  } roundMode_e;

  typedef struct packed {
    logic loadProd;
    logic loadRes;
  } stageStrobes_t;
endpackage

// File: rtl/sat_frac_mul_ctrl.sv
module sat_frac_mul_ctrl
  import sat_frac_mul_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          satClear,
  input  logic          satDetect,
  output stageStrobes_t strobes,
  output logic          outValid,
  output logic          satFlag
);
  logic prodValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodValid <= 1'b0;
      outValid  <= 1'b0;
      satFlag   <= 1'b0;
    end else begin
      prodValid <= inValid;
      outValid  <= prodValid;
      satFlag   <= (satFlag & ~satClear) | (prodValid & satDetect);
    end
  end

  always_comb begin
    strobes.loadProd = inValid;
    strobes.loadRes  = prodValid;
  end
endmodule

// File: rtl/sat_frac_mul_dp.sv
module sat_frac_mul_dp
  import sat_frac_mul_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic            clk,
  input  stageStrobes_t   strobes,
  input  logic            scalarSel,
  input  logic [SEW-1:0]  vecA,
  input  logic [SEW-1:0]  scalarA,
  input  logic [SEW-1:0]  vecB,
  input  logic [1:0]      roundMode,
  output logic [SEW-1:0]  result,
  output logic            satDetect
);
  localparam int PW = 2 * SEW;
  localparam int D  = SEW - 1;
  localparam logic signed [PW:0] MAXV = {{(PW - SEW + 2){1'b0}}, {(SEW - 1){1'b1}}};
  localparam logic signed [PW:0] MINV = {{(PW - SEW + 2){1'b1}}, {(SEW - 1){1'b0}}};

  logic signed [SEW-1:0] opA;
  logic signed [PW-1:0]  prodQ;
  roundMode_e            modeQ;
  logic signed [PW-1:0]  shifted;
  logic signed [PW:0]    sum;
  logic                  incr;
  logic                  halfBit, keepLsb, restNz;
  logic [SEW-1:0]        clamped;

  assign opA = scalarSel ? scalarA : vecA;

  always_ff @(posedge clk) begin
    if (strobes.loadProd) begin
      prodQ <= opA * $signed(vecB);
      modeQ <= roundMode_e'(roundMode);
    end
  end

  always_comb begin
    halfBit = prodQ[D-1];
    keepLsb = prodQ[D];
    restNz  = |prodQ[D-2:0];
    unique case (modeQ)
      RND_NEAR_UP:   incr = halfBit;
      RND_NEAR_EVEN: incr = halfBit & (keepLsb | restNz);
      RND_TRUNC:     incr = 1'b0;
      default:       incr = ~keepLsb & (halfBit | restNz);
    endcase
    shifted = prodQ >>> D;
    sum     = {shifted[PW-1], shifted} + {{PW{1'b0}}, incr};
    if (sum > MAXV) begin
      clamped   = MAXV[SEW-1:0];
      satDetect = 1'b1;
    end else if (sum < MINV) begin
      clamped   = MINV[SEW-1:0];
      satDetect = 1'b1;
    end else begin
      clamped   = sum[SEW-1:0];
      satDetect = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadRes) result <= clamped;
  end
endmodule

// File: rtl/sat_frac_mul.sv
module sat_frac_mul
  import sat_frac_mul_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           scalarSel,
  input  logic [SEW-1:0] vecA,
  input  logic [SEW-1:0] scalarA,
  input  logic [SEW-1:0] vecB,
  input  logic [1:0]     roundMode,
  input  logic           satClear,
  output logic           outValid,
  output logic [SEW-1:0] result,
  output logic           satFlag
);
  stageStrobes_t strobes;
  logic          satDetect;

  sat_frac_mul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .satClear(satClear),
    .satDetect(satDetect), .strobes(strobes), .outValid(outValid),
    .satFlag(satFlag)
  );

  sat_frac_mul_dp #(.SEW(SEW)) u_dp (
    .clk(clk), .strobes(strobes), .scalarSel(scalarSel), .vecA(vecA),
    .scalarA(scalarA), .vecB(vecB), .roundMode(roundMode),
    .result(result), .satDetect(satDetect)
  );
endmodule

// File: rtl/sat_frac_mul_chk.sv
module sat_frac_mul_chk #(
  parameter int SEW = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           satClear,
  input logic           outValid,
  input logic [SEW-1:0] result,
  input logic           satFlag
);
  localparam logic [SEW-1:0] MAXP = {1'b0, {(SEW - 1){1'b1}}};
  localparam logic [SEW-1:0] MINN = {1'b1, {(SEW - 1){1'b0}}};

  assert_reset_clears_R11: assert property (@(posedge clk)
    !rstN |=> (!outValid && !satFlag));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !satClear) |=> satFlag);

  assert_sat_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> (outValid && (result == MAXP || result == MINN)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    satClear |=> (!satFlag || outValid));
endmodule

bind sat_frac_mul sat_frac_mul_chk #(.SEW(SEW)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .satClear(satClear),
  .outValid(outValid), .result(result), .satFlag(satFlag)
);

// File: tb/tb_sat_frac_mul.sv
module tb_sat_frac_mul;
  localparam int SEW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, scalarSel = 1'b0, satClear = 1'b0;
  logic [SEW-1:0] vecA = '0, scalarA = '0, vecB = '0;
  logic [1:0] roundMode = 2'd0;
  logic outValid, satFlag;
  logic [SEW-1:0] result;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sat_frac_mul #(.SEW(SEW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .scalarSel(scalarSel),
    .vecA(vecA), .scalarA(scalarA), .vecB(vecB), .roundMode(roundMode),
    .satClear(satClear), .outValid(outValid), .result(result), .satFlag(satFlag)
  );

  task automatic check(string req, logic [SEW-1:0] act, logic [SEW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SEW-1:0] model(logic [15:0] a, logic [15:0] b,
                                           int mode, output bit sat);
    longint p, sh, s;
    bit half, lsb, rest, inc;
    p    = longint'($signed(a)) * longint'($signed(b));
    sh   = p >>> 15;
    half = p[14]; lsb = p[15]; rest = (p & 64'h3fff) != 0;
    case (mode)
      0: inc = half;
      1: inc = half & (lsb | rest);
      2: inc = 0;
      default: inc = !lsb & (half | rest);
    endcase
    s = sh + longint'(inc);
    sat = 0;
    if (s > 32767) begin s = 32767; sat = 1; end
    if (s < -32768) begin s = -32768; sat = 1; end
    return s[15:0];
  endfunction

  // One element: issue, then sample two edges later between edges.
  task automatic runOne(string req, logic [15:0] a, logic [15:0] b, int mode,
                        logic sel, logic [15:0] sc, logic [15:0] exp,
                        logic clrAtStage2 = 1'b0);
    @(negedge clk);
    inValid = 1; vecA = a; vecB = b; roundMode = 2'(mode); scalarSel = sel; scalarA = sc;
    @(negedge clk);
    inValid = 0; satClear = clrAtStage2;
    check({req, " valid low mid-pipe (R10)"}, {15'd0, outValid}, 16'd0);
    @(negedge clk);
    satClear = 0;
    check({req, " valid (R10)"}, {15'd0, outValid}, 16'd1);
    check(req, result, exp);
  endtask

  task automatic testReset();
    check("R11 outValid after reset", {15'd0, outValid}, 16'd0);
    check("R11 satFlag after reset", {15'd0, satFlag}, 16'd0);
  endtask

  task automatic testHalfTies();
    // p = +0.5 lsb with even keep: 1 * 0x4000
    runOne("R2 tie even up", 16'h0001, 16'h4000, 0, 0, 0, 16'h0001);
    runOne("R3 tie even stays", 16'h0001, 16'h4000, 1, 0, 0, 16'h0000);
    runOne("R4 tie trunc", 16'h0001, 16'h4000, 2, 0, 0, 16'h0000);
    runOne("R5 tie odd", 16'h0001, 16'h4000, 3, 0, 0, 16'h0001);
    // odd keep part: 3 * 0x4000, p = 0xC000
    runOne("R2 odd keep", 16'h0003, 16'h4000, 0, 0, 0, 16'h0002);
    runOne("R3 odd keep to even", 16'h0003, 16'h4000, 1, 0, 0, 16'h0002);
    runOne("R4 odd keep trunc", 16'h0003, 16'h4000, 2, 0, 0, 16'h0001);
    runOne("R5 odd keep stays", 16'h0003, 16'h4000, 3, 0, 0, 16'h0001);
    // negative tie: -1 * 0x4000
    runOne("R2 negative tie", 16'hffff, 16'h4000, 0, 0, 0, 16'h0000);
    runOne("R3 negative tie", 16'hffff, 16'h4000, 1, 0, 0, 16'h0000);
    runOne("R4 negative floor", 16'hffff, 16'h4000, 2, 0, 0, 16'hffff);
    runOne("R5 negative odd", 16'hffff, 16'h4000, 3, 0, 0, 16'hffff);
  endtask

  task automatic testMix();
    logic [15:0] as[8] = '{16'h4000, 16'h7fff, 16'h8001, 16'h1234, 16'hc321, 16'h0005, 16'hffff, 16'h5a5a};
    logic [15:0] bs[8] = '{16'h4000, 16'h7fff, 16'h7fff, 16'hfedc, 16'h6789, 16'h0007, 16'h8000, 16'ha5a5};
    bit s;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++)
        runOne($sformatf("R1 mix mode%0d pair%0d", m, i), as[i], bs[i], m, 0, 0,
               model(as[i], bs[i], m, s));
    check("R7 no flag from in-range mix", {15'd0, satFlag}, 16'd0);
  endtask

  task automatic testSaturation();
    runOne("R6 min*min clamps", 16'h8000, 16'h8000, 0, 0, 0, 16'h7fff);
    check("R6 flag set", {15'd0, satFlag}, 16'd1);
    runOne("R7 later result", 16'h4000, 16'h4000, 2, 0, 0, 16'h2000);
    check("R7 flag still set", {15'd0, satFlag}, 16'd1);
    @(negedge clk); satClear = 1;
    @(negedge clk); satClear = 0;
    check("R8 clear alone", {15'd0, satFlag}, 16'd0);
    runOne("R8 saturate with clear", 16'h8000, 16'h8000, 3, 0, 0, 16'h7fff, 1'b1);
    check("R8 saturation beats clear", {15'd0, satFlag}, 16'd1);
    runOne("R8 clear with plain element", 16'h4000, 16'h4000, 0, 0, 0, 16'h2000, 1'b1);
    check("R8 flag cleared", {15'd0, satFlag}, 16'd0);
  endtask

  task automatic testScalar();
    runOne("R9 scalar used", 16'h7fff, 16'h4000, 2, 1, 16'h2000, 16'h1000);
    runOne("R9 vector used", 16'h7fff, 16'h4000, 2, 0, 16'h2000, 16'h3fff);
  endtask

  task automatic testStream();
    logic [15:0] a[4] = '{16'h0001, 16'h0003, 16'h6000, 16'h8000};
    logic [15:0] b[4] = '{16'h4000, 16'h4000, 16'h6000, 16'h8000};
    logic        sel[4] = '{0, 1, 0, 0};
    logic [15:0] exp[4] = '{16'h0001, 16'h0004, 16'h4800, 16'h7fff};
    // element 1 uses scalar 0x0005 with 0x4000: p=0x14000, keep 2, tie, mode 3 -> 3
    int          md[4] = '{0, 3, 2, 1};
    exp[1] = 16'h0003;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check($sformatf("R10 stream valid %0d", i - 2), {15'd0, outValid}, 16'd1);
        check($sformatf("R1 stream result %0d", i - 2), result, exp[i - 2]);
      end
      if (i < 4) begin
        inValid = 1; vecA = a[i]; vecB = b[i]; scalarSel = sel[i];
        scalarA = 16'h0005; roundMode = 2'(md[i]);
      end else inValid = 0;
    end
    @(negedge clk);
    check("R10 stream drained", {15'd0, outValid}, 16'd0);
    check("R6 stream saturation flag", {15'd0, satFlag}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testHalfTies();
    testMix();
    testSaturation();
    testScalar();
    testStream();
    @(negedge clk); rstN = 0;
    @(negedge clk);
    testReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule